// File: doc/BRIEF.md
# Two-Channel Spur-Cancelling Tone Synthesizer

This block produces one signed DAC sample per clock from two numerically controlled sine channels whose scaled outputs are added digitally. The main channel makes the wanted tone. The auxiliary channel is set to the frequency and amplitude of a known unwanted spur, with its phase turned half a cycle away from that spur. When the two channels are added, the spur cancels before the sample ever reaches a converter.

Each channel keeps a phase accumulator, adds a phase offset, converts phase to a cosine value, and scales that value by an amplitude word. Software writes staging values on the input ports. These values reach the active registers of both channels only on an update strobe, so that both channels change on the same clock. Every channel has a two-state controller. `CH_IDLE` holds the accumulator at zero and produces zero. `CH_RUN` advances the accumulator. The *start* transition (IDLE to RUN) happens on an update while the channel enable is high. The *stop* transition (RUN to IDLE) happens on an update while it is low. The main channel's enable is tied high, so its first update starts it. The sum is clipped to the signed output range instead of wrapping.

Top module: `spur_cancel_synth`

## Requirements
- R1: While reset is held and after it is released, `dac_out` is 0 until the first update.
- R2: The staging ports have no effect on `dac_out` until `update` is pulsed.
- R3: Values captured on an update edge E appear at `dac_out` together for both channels after the third clock edge following E; after the second edge the old value is still shown.
- R4: With a zero tuning word, a 14-bit phase value of 0x0000 gives +amp, 0x1000 gives 0, 0x2000 gives -amp and 0x3000 gives 0, for an amplitude of 511 or less on one channel.
- R5: The accumulator adds the 32-bit tuning word every clock, and its upper 14 bits plus the offset form the phase. A tuning word of 0x4000_0000 steps the output through +amp, 0, -amp, 0, +amp on consecutive samples, starting from phase 0 after reset.
- R6: `aux_invert` = 1 adds 0x2000 to the auxiliary phase offset, modulo 2^14.
- R7: A disabled auxiliary channel contributes 0 and its accumulator stays at zero. Enabling it again restarts it at phase 0 plus its offset.
- R8: The sum saturates to +511 and to -512 rather than wrapping.
- R9: An auxiliary channel programmed as an inverted copy of the main channel keeps `|dac_out| <= 1` on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| update | input | 1 | Moves all staging values into the active registers |
| main_ftw | input | 32 | Main tuning word (staging) |
| main_poff | input | 14 | Main phase offset (staging) |
| main_amp | input | 10 | Main amplitude, unsigned (staging) |
| aux_en | input | 1 | Auxiliary channel enable (staging) |
| aux_invert | input | 1 | Adds a half turn to the auxiliary offset (staging) |
| aux_ftw | input | 32 | Auxiliary tuning word (staging) |
| aux_poff | input | 14 | Auxiliary phase offset (staging) |
| aux_amp | input | 10 | Auxiliary amplitude, unsigned (staging) |
| dac_out | output | 10 | Saturated signed sum sample |

## Verification
The bench uses the default parameters: a 32-bit tuning word, a 14-bit phase, a 10-bit amplitude and a 10-bit output. With these values a tuning word of 2^30 advances the phase by exactly a quarter turn, so exact quadrant values can be expected on every sample. An amplitude of up to 1023 on each channel drives the sum beyond the ±512 output range at both ends, which makes saturation reachable. Inverted-copy runs with arbitrary tuning words then cover the cancellation path across the whole phase circle.

// File: rtl/spur_pkg.sv
package spur_pkg;
    localparam int FTW_W_DEF = 32;
    localparam int PH_W_DEF  = 14;
    localparam int AMP_W_DEF = 10;
    localparam int OUT_W_DEF = 10;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;
endpackage

// File: rtl/sc_cos_amp.sv
// Phase to scaled cosine: quadrant folding, quarter-wave polynomial, sign-magnitude scaling.
module sc_cos_amp #(
    parameter int PH_W  = spur_pkg::PH_W_DEF,
    parameter int AMP_W = spur_pkg::AMP_W_DEF
) (
    input  logic [PH_W-1:0]         phase,
    input  logic [AMP_W-1:0]        amp,
    output logic signed [AMP_W:0]   smp
);
    localparam int          FR_W = PH_W - 2;
    localparam logic [31:0] ONE  = 32'd1 << FR_W;
    // cos(pi/2*u) ~ 1 - u^2*(A - B*u^2), with A ~ 1.2337 and B ~ 0.2337 in Q(FR_W)
    localparam logic [31:0] A_C  = (32'd5053 << FR_W) >> 12;
    localparam logic [31:0] B_C  = (32'd957  << FR_W) >> 12;

    logic [1:0]       quad;
    logic [FR_W-1:0]  frac;
    logic             neg;
    logic [31:0]      u, u2, inner, prod, c;
    logic [AMP_W-1:0] mag;

    always_comb begin
        quad  = phase[PH_W-1 -: 2];
        frac  = phase[FR_W-1:0];
        neg   = quad[1] ^ quad[0];
        u     = quad[0] ? (ONE - 32'(frac)) : 32'(frac);
        u2    = (u * u) >> FR_W;
        inner = A_C - ((B_C * u2) >> FR_W);
        prod  = (u2 * inner) >> FR_W;
        c     = (prod >= ONE) ? 32'd0 : (ONE - prod);
        mag   = AMP_W'((c * 32'(amp)) >> FR_W);
        smp   = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/sc_channel.sv
// One synthesis channel: active registers, run/idle controller, accumulator, two pipeline stages.
module sc_channel
    import spur_pkg::*;
#(
    parameter int FTW_W = FTW_W_DEF,
    parameter int PH_W  = PH_W_DEF,
    parameter int AMP_W = AMP_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   en,
    input  logic [FTW_W-1:0]       ftw,
    input  logic [PH_W-1:0]        poff,
    input  logic [AMP_W-1:0]       amp,
    output logic signed [AMP_W:0]  smp
);
    ch_state_t             state_q, state_d;
    logic [FTW_W-1:0]      ftw_a, acc_q;
    logic [PH_W-1:0]       poff_a, phase_q;
    logic [AMP_W-1:0]      amp_a, amp_q;
    logic                  on_q;
    logic signed [AMP_W:0] cos_w, smp_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (load && en)  state_d = CH_RUN;   // start
            CH_RUN:  if (load && !en) state_d = CH_IDLE;  // stop
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // active registers and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_a   <= '0;
            poff_a  <= '0;
            amp_a   <= '0;
            acc_q   <= '0;
            phase_q <= '0;
            amp_q   <= '0;
            on_q    <= 1'b0;
            smp_q   <= '0;
        end else begin
            if (load) begin
                ftw_a  <= ftw;
                poff_a <= poff;
                amp_a  <= amp;
            end
            if (state_q == CH_RUN && state_d == CH_RUN) acc_q <= acc_q + ftw_a;
            else                                        acc_q <= '0;
            phase_q <= acc_q[FTW_W-1 -: PH_W] + poff_a;
            amp_q   <= amp_a;
            on_q    <= (state_q == CH_RUN);
            smp_q   <= on_q ? cos_w : '0;
        end
    end

    sc_cos_amp #(.PH_W(PH_W), .AMP_W(AMP_W)) u_cos (
        .phase (phase_q),
        .amp   (amp_q),
        .smp   (cos_w)
    );

    assign smp = smp_q;
endmodule

// File: rtl/sc_sat_sum.sv
// Adds two channel samples at extended width and clips to the signed output range.
module sc_sat_sum #(
    parameter int AMP_W = spur_pkg::AMP_W_DEF,
    parameter int OUT_W = spur_pkg::OUT_W_DEF
) (
    input  logic signed [AMP_W:0]   a,
    input  logic signed [AMP_W:0]   b,
    output logic signed [OUT_W-1:0] y
);
    localparam int S_W = AMP_W + 2;
    localparam logic signed [S_W-1:0] MAXV = S_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [S_W-1:0] MINV = -MAXV - S_W'(1);

    logic signed [S_W-1:0] sum;

    always_comb begin
        sum = S_W'(a) + S_W'(b);
        if (sum > MAXV)      y = OUT_W'(MAXV);
        else if (sum < MINV) y = OUT_W'(MINV);
        else                 y = OUT_W'(sum);
    end
endmodule

// File: rtl/spur_cancel_synth.sv
module spur_cancel_synth
    import spur_pkg::*;
#(
    parameter int FTW_W = FTW_W_DEF,
    parameter int PH_W  = PH_W_DEF,
    parameter int AMP_W = AMP_W_DEF,
    parameter int OUT_W = OUT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    update,
    input  logic [FTW_W-1:0]        main_ftw,
    input  logic [PH_W-1:0]         main_poff,
    input  logic [AMP_W-1:0]        main_amp,
    input  logic                    aux_en,
    input  logic                    aux_invert,
    input  logic [FTW_W-1:0]        aux_ftw,
    input  logic [PH_W-1:0]         aux_poff,
    input  logic [AMP_W-1:0]        aux_amp,
    output logic signed [OUT_W-1:0] dac_out
);
    localparam logic [PH_W-1:0] HALF_TURN = PH_W'(1) << (PH_W - 1);

    logic [PH_W-1:0]        aux_poff_eff;
    logic signed [AMP_W:0]  main_smp, aux_smp;
    logic signed [OUT_W-1:0] sum_w, dac_q;

    assign aux_poff_eff = aux_poff + (aux_invert ? HALF_TURN : '0);

    sc_channel #(.FTW_W(FTW_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_main (
        .clk (clk), .rst_n (rst_n), .load (update), .en (1'b1),
        .ftw (main_ftw), .poff (main_poff), .amp (main_amp), .smp (main_smp)
    );

    sc_channel #(.FTW_W(FTW_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_aux (
        .clk (clk), .rst_n (rst_n), .load (update), .en (aux_en),
        .ftw (aux_ftw), .poff (aux_poff_eff), .amp (aux_amp), .smp (aux_smp)
    );

    sc_sat_sum #(.AMP_W(AMP_W), .OUT_W(OUT_W)) u_sum (
        .a (main_smp), .b (aux_smp), .y (sum_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) dac_q <= '0;
        else        dac_q <= sum_w;
    end

    assign dac_out = dac_q;
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int FTW_W = 32,
    parameter int AMP_W = 10,
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    update,
    input logic                    main_run,
    input logic                    aux_run,
    input logic                    aux_on,
    input logic [FTW_W-1:0]        main_acc,
    input logic [FTW_W-1:0]        main_ftw_a,
    input logic [FTW_W-1:0]        aux_acc,
    input logic [FTW_W-1:0]        aux_ftw_a,
    input logic [AMP_W-1:0]        main_amp_a,
    input logic signed [AMP_W:0]   main_smp,
    input logic signed [AMP_W:0]   aux_smp,
    input logic signed [OUT_W-1:0] dac
);
    localparam int S_W = AMP_W + 2;
    localparam logic signed [S_W-1:0]   MAXS = S_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [S_W-1:0]   MINS = -MAXS - S_W'(1);
    localparam logic signed [OUT_W-1:0] MAXO = OUT_W'(MAXS);
    localparam logic signed [OUT_W-1:0] MINO = OUT_W'(MINS);

    logic signed [S_W-1:0] raw_sum;
    assign raw_sum = S_W'(main_smp) + S_W'(aux_smp);

    AST_SHADOW_FTW: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(aux_ftw_a));                                   // R2
    AST_SHADOW_AMP: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(main_amp_a));                                  // R2
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (main_run && !update) |=> (main_acc == $past(main_acc) + $past(main_ftw_a))); // R5
    AST_AUX_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_run |=> (aux_acc == '0));                                     // R7
    AST_AUX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_on |=> (aux_smp == '0));                                      // R7
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_sum > MAXS) |=> (dac == MAXO));                               // R8
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_sum < MINS) |=> (dac == MINO));                               // R8
endmodule

bind spur_cancel_synth sc_checker #(.FTW_W(FTW_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .update     (update),
    .main_run   (u_main.state_q == spur_pkg::CH_RUN),
    .aux_run    (u_aux.state_q == spur_pkg::CH_RUN),
    .aux_on     (u_aux.on_q),
    .main_acc   (u_main.acc_q),
    .main_ftw_a (u_main.ftw_a),
    .aux_acc    (u_aux.acc_q),
    .aux_ftw_a  (u_aux.ftw_a),
    .main_amp_a (u_main.amp_a),
    .main_smp   (main_smp),
    .aux_smp    (aux_smp),
    .dac        (dac_out)
);

// File: tb/spur_cancel_synth_test.sv
`timescale 1ns/1ps
module spur_cancel_synth_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              update = 1'b0;
    logic [31:0]       main_ftw = '0, aux_ftw = '0;
    logic [13:0]       main_poff = '0, aux_poff = '0;
    logic [9:0]        main_amp = '0, aux_amp = '0;
    logic              aux_en = 1'b0, aux_invert = 1'b0;
    logic signed [9:0] dac;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spur_cancel_synth uut (
        .clk (clk), .rst_n (rst_n), .update (update),
        .main_ftw (main_ftw), .main_poff (main_poff), .main_amp (main_amp),
        .aux_en (aux_en), .aux_invert (aux_invert),
        .aux_ftw (aux_ftw), .aux_poff (aux_poff), .aux_amp (aux_amp),
        .dac_out (dac)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update = 1'b1;
        @(posedge clk);
        @(negedge clk);
        update = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        update = 1'b0;
        main_ftw = '0; main_poff = '0; main_amp = '0;
        aux_ftw = '0;  aux_poff = '0;  aux_amp = '0;
        aux_en = 1'b0; aux_invert = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 after reset", int'(dac), 0);
        main_amp = 10'd300;
        step(5);
        check("R1 before first update", int'(dac), 0);
    endtask

    task automatic t_quadrants();
        do_reset();
        main_amp = 10'd300;
        main_poff = 14'h0000; pulse_update(); step(3);
        check("R4 phase 0x0000", int'(dac), 300);
        main_poff = 14'h1000; pulse_update(); step(3);
        check("R4 phase 0x1000", int'(dac), 0);
        main_poff = 14'h2000; pulse_update(); step(3);
        check("R4 phase 0x2000", int'(dac), -300);
        main_poff = 14'h3000; pulse_update(); step(3);
        check("R4 phase 0x3000", int'(dac), 0);
    endtask

    task automatic t_shadow();
        do_reset();
        main_amp = 10'd300; pulse_update(); step(3);
        check("R2 baseline", int'(dac), 300);
        main_amp = 10'd100; main_poff = 14'h2000;
        aux_en = 1'b1; aux_amp = 10'd50;
        step(6);
        check("R2 staging ignored", int'(dac), 300);
        main_poff = 14'h0000; main_amp = 10'd200; aux_en = 1'b0;
        pulse_update(); step(3);
        check("R3 setup", int'(dac), 200);
        main_amp = 10'd100; aux_en = 1'b1; aux_amp = 10'd50; aux_poff = 14'h0000;
        pulse_update(); step(2);
        check("R3 old value after two edges", int'(dac), 200);
        step(1);
        check("R3 both channels after three edges", int'(dac), 150);
    endtask

    task automatic t_step();
        do_reset();
        main_amp = 10'd300; main_ftw = 32'h4000_0000;
        pulse_update(); step(3);
        check("R5 sample 0", int'(dac), 300);
        step(1); check("R5 sample 1", int'(dac), 0);
        step(1); check("R5 sample 2", int'(dac), -300);
        step(1); check("R5 sample 3", int'(dac), 0);
        step(1); check("R5 sample 4", int'(dac), 300);
    endtask

    task automatic t_invert();
        do_reset();
        aux_en = 1'b1; aux_amp = 10'd250; aux_invert = 1'b1; aux_poff = 14'h0000;
        pulse_update(); step(3);
        check("R6 invert at offset 0", int'(dac), -250);
        aux_poff = 14'h2000;
        pulse_update(); step(3);
        check("R6 invert wraps modulo", int'(dac), 250);
    endtask

    task automatic t_aux_off();
        do_reset();
        main_amp = 10'd100;
        aux_en = 1'b0; aux_amp = 10'd500; aux_ftw = 32'h4000_0000;
        pulse_update(); step(3);
        check("R7 disabled aux adds nothing", int'(dac), 100);
        main_amp = 10'd0; aux_en = 1'b1; aux_amp = 10'd200;
        pulse_update(); step(3);
        check("R7 enabled aux sample 0", int'(dac), 200);
        step(1);
        check("R7 enabled aux sample 1", int'(dac), 0);
        aux_en = 1'b0;
        pulse_update(); step(5);
        check("R7 disabled aux silent", int'(dac), 0);
        aux_en = 1'b1;
        pulse_update(); step(3);
        check("R7 restart from phase 0", int'(dac), 200);
        step(1);
        check("R7 restart second sample", int'(dac), 0);
    endtask

    task automatic t_sat();
        do_reset();
        main_amp = 10'd1023; aux_en = 1'b1; aux_amp = 10'd1023;
        pulse_update(); step(3);
        check("R8 positive clip", int'(dac), 511);
        main_poff = 14'h2000; aux_poff = 14'h2000;
        pulse_update(); step(3);
        check("R8 negative clip", int'(dac), -512);
        main_amp = 10'd300; aux_amp = 10'd200;
        pulse_update(); step(3);
        check("R8 in-range sum", int'(dac), -500);
    endtask

    task automatic t_cancel(input logic [31:0] ftw, input logic [13:0] poff,
                            input logic [9:0] amp, input logic use_inv);
        int worst;
        do_reset();
        main_ftw = ftw; main_poff = poff; main_amp = amp;
        aux_en = 1'b1; aux_ftw = ftw; aux_amp = amp;
        aux_invert = use_inv;
        aux_poff = use_inv ? poff : poff + 14'h2000;
        pulse_update(); step(3);
        worst = 0;
        for (int i = 0; i < 2000; i++) begin
            if ((int'(dac) > 1 || int'(dac) < -1) && worst == 0) worst = int'(dac);
            step(1);
        end
        check("R9 inverted copy cancels", worst, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_quadrants();
        t_shadow();
        t_step();
        t_invert();
        t_aux_off();
        t_sat();
        t_cancel(32'h1234_5678, 14'h0123, 10'd700, 1'b1);
        t_cancel(32'h0A3D_70A4, 14'h3F00, 10'd1023, 1'b0);
        t_cancel($urandom, 14'($urandom), 10'd511, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule